// File: doc/BRIEF.md
# Bottom-Up Raster Image Loader

This block takes a byte stream that carries a small 8-bit-per-pixel image file and writes its pixels into a frame memory, one byte per address, in ordinary top-down raster order. The stream opens with a fixed 32-bit identification word. Two 32-bit fields follow, first the width and then the height. The pixel bytes come after them, one per pixel in RGB 3-3-2 form. The file holds its rows with the lowest screen row first and the top row last, and each row runs left to right. The loader therefore places every row from the bottom of the frame upward.

The stream side is a valid/ready byte interface. The memory side is a byte-wide write port with a stall input. When the memory stalls, the loader lowers its ready, so no byte is dropped. A bad identification word, or a width or height outside the allowed range, sets a sticky error flag. After that the loader accepts and discards all further bytes until reset. A good image ends with a one-cycle done pulse, and the loader is then ready for the next file.

Top module: `img_loader`

## Requirements
- R1: After reset, s_ready is 1, mem_we is 0, done is 0 and error is 0.
- R2: The first four stream bytes, taken most significant first, must form 32'hDEAD1337. Any other value sets error, and no memory write and no done pulse follow.
- R3: Bytes 5 to 8 form the width and bytes 9 to 12 form the height, each most significant byte first. A width of zero or above MAX_W, or a height of zero or above MAX_H, sets error before any pixel write.
- R4: The k-th pixel byte (k from 0) sits in file row r = k / width and column c = k mod width. It is written unchanged to address (height-1-r)*width + c.
- R5: Exactly width*height writes are made. done is high for exactly one cycle after the last write, and the loader then accepts a new header without reset.
- R6: In the pixel phase, s_ready is low in every cycle in which mem_stall is high, and no pixel byte is lost or duplicated under stalls or source gaps.
- R7: Once error is set it stays set until reset. s_ready stays high, every byte is discarded, and done stays low.
- R8: mem_we is high only in a cycle where s_valid is high and the stream is in its pixel phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Stream byte present |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Loader accepts the byte this cycle |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Frame memory byte address |
| mem_data | output | 8 | Pixel byte to write |
| mem_stall | input | 1 | Memory cannot take a write this cycle |
| done | output | 1 | One-cycle pulse after the final pixel write |
| error | output | 1 | Sticky header fault flag |

## Verification
Several rules are checked on every cycle. A write needs a valid byte and may not appear once the error flag is set. Ready falls while a requested write is stalled. The error flag never clears on its own, done never lasts two cycles, and every write address falls inside the frame. Other properties can only be shown by the bench scenarios, because each one depends on a whole image. These are the bottom-up address mapping across many random sizes, the exact write count, the one-cycle done pulse at the end of an image, header rejection for each bad field, and a clean restart on back-to-back files.

// File: rtl/img_loader_pkg.sv
// Shared definitions for the raster image loader.
package img_loader_pkg;
    // Identification word expected at the head of each file.
    localparam logic [31:0] FILE_TAG = 32'hDEAD1337;

    // Top-level sequencing states.
    typedef enum logic [2:0] {
        LD_HDR,    // collecting the 12 header bytes
        LD_SETUP,  // computing the base address of the bottom row
        LD_PIX,    // streaming pixel bytes to memory
        LD_DONE,   // single-cycle completion pulse
        LD_DRAIN   // header fault: swallow input until reset
    } ld_state_t;
endpackage

// File: rtl/img_hdr_parse.sv
// Header parser. It counts the 12 header bytes and checks the identification
// word after byte 4. It captures the width after byte 8 and validates both
// dimensions after byte 12.
// Assumes: take is high only for bytes accepted while the header is being read.
module img_hdr_parse #(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480,
    localparam int WW = $clog2(MAX_W + 1),
    localparam int HW = $clog2(MAX_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [7:0]    data,
    output logic          hdr_ok,
    output logic          hdr_bad,
    output logic [WW-1:0] width_o,
    output logic [HW-1:0] height_o
);
    import img_loader_pkg::*;

    logic [3:0]  idx_q;
    logic [23:0] shift_q;
    logic [31:0] width_q;
    logic [31:0] field;
    logic        dims_good;
    logic        tag_bad;

    assign field     = {shift_q, data};
    assign tag_bad   = take && (idx_q == 4'd3) && (field != FILE_TAG);
    assign dims_good = (width_q != 32'd0) && (width_q <= 32'(MAX_W)) &&
                       (field != 32'd0) && (field <= 32'(MAX_H));
    assign hdr_ok    = take && (idx_q == 4'd11) && dims_good;
    assign hdr_bad   = tag_bad || (take && (idx_q == 4'd11) && !dims_good);
    assign width_o   = width_q[WW-1:0];
    assign height_o  = field[HW-1:0];

    // Byte index within the header; it restarts after each verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (hdr_ok || hdr_bad) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 4'd1;
        end
    end

    // Assembles bytes most significant first and keeps the width field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            width_q <= '0;
        end else if (take) begin
            shift_q <= field[23:0];
            if (idx_q == 4'd7) begin
                width_q <= field;
            end
        end
    end
endmodule

// File: rtl/img_addr_gen.sv
// Destination address generator. On start it forms (height-1)*width by
// shift-and-add over HW cycles with busy high. Each step then advances one
// column. At the end of a row it moves the row base up by one width.
// Assumes: 1 <= width <= MAX_W and 1 <= height <= MAX_H at start.
module img_addr_gen #(
    parameter int WW = 10,
    parameter int HW = 9,
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] w_in,
    input  logic [HW-1:0] h_in,
    input  logic          step,
    output logic          busy,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam int CW = $clog2(HW + 1);

    logic [WW-1:0] w_q;
    logic [WW-1:0] col_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] mcand_q;
    logic [HW-1:0] mplier_q;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_next;
    logic [CW-1:0] iter_q;
    logic          row_end;

    assign acc_next = acc_q + (mplier_q[0] ? mcand_q : '0);
    assign row_end  = (col_q == w_q - 1'b1);
    assign last     = !busy && row_end && (base_q == '0);

    // Bottom-row base multiply, then column and row stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q      <= '0;
            col_q    <= '0;
            base_q   <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            iter_q   <= '0;
            busy     <= 1'b0;
            addr     <= '0;
        end else if (start) begin
            w_q      <= w_in;
            col_q    <= '0;
            mcand_q  <= AW'(w_in);
            mplier_q <= h_in - 1'b1;
            acc_q    <= '0;
            iter_q   <= CW'(HW);
            busy     <= 1'b1;
        end else if (busy) begin
            acc_q    <= acc_next;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            iter_q   <= iter_q - 1'b1;
            if (iter_q == CW'(1)) begin
                busy   <= 1'b0;
                base_q <= acc_next;
                addr   <= acc_next;
            end
        end else if (step) begin
            if (row_end) begin
                col_q  <= '0;
                base_q <= base_q - AW'(w_q);
                addr   <= base_q - AW'(w_q);
            end else begin
                col_q  <= col_q + 1'b1;
                addr   <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/img_loader.sv
// Top level of the raster image loader. It sequences header parsing, base
// address setup, pixel writes and completion. The memory write port is a
// direct pass-through of the stream byte, qualified by the pixel state.
// Assumes: memory takes a write in a cycle with mem_we high and mem_stall low.
module img_loader #(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480,
    localparam int WW = $clog2(MAX_W + 1),
    localparam int HW = $clog2(MAX_H + 1),
    localparam int AW = $clog2(MAX_W * MAX_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    output logic          s_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    input  logic          mem_stall,
    output logic          done,
    output logic          error
);
    import img_loader_pkg::*;

    ld_state_t     state_q;
    logic          take_hdr;
    logic          hdr_ok;
    logic          hdr_bad;
    logic [WW-1:0] width_w;
    logic [HW-1:0] height_w;
    logic          gen_busy;
    logic          gen_last;
    logic          pix_wr;

    assign take_hdr = (state_q == LD_HDR) && s_valid;
    assign mem_we   = (state_q == LD_PIX) && s_valid;
    assign pix_wr   = mem_we && !mem_stall;
    assign mem_data = s_data;
    assign done     = (state_q == LD_DONE);

    // Stream ready per state; pixel bytes wait for the memory.
    always_comb begin
        case (state_q)
            LD_HDR:   s_ready = 1'b1;
            LD_PIX:   s_ready = !mem_stall;
            LD_DRAIN: s_ready = 1'b1;
            default:  s_ready = 1'b0;
        endcase
    end

    img_hdr_parse #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take_hdr),
        .data     (s_data),
        .hdr_ok   (hdr_ok),
        .hdr_bad  (hdr_bad),
        .width_o  (width_w),
        .height_o (height_w)
    );

    img_addr_gen #(.WW(WW), .HW(HW), .AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (hdr_ok),
        .w_in  (width_w),
        .h_in  (height_w),
        .step  (pix_wr),
        .busy  (gen_busy),
        .addr  (mem_addr),
        .last  (gen_last)
    );

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_HDR;
        end else begin
            case (state_q)
                LD_HDR: begin
                    if (hdr_bad)     state_q <= LD_DRAIN;
                    else if (hdr_ok) state_q <= LD_SETUP;
                end
                LD_SETUP: if (!gen_busy) state_q <= LD_PIX;
                LD_PIX:   if (pix_wr && gen_last) state_q <= LD_DONE;
                LD_DONE:  state_q <= LD_HDR;
                default:  state_q <= LD_DRAIN;
            endcase
        end
    end

    // Sticky fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       error <= 1'b0;
        else if (hdr_bad) error <= 1'b1;
    end
endmodule

// File: rtl/img_loader_chk.sv
// Cycle-level protocol checker for img_loader, attached by bind.
module img_loader_chk #(
    parameter int MAX_W = 640,
    parameter int MAX_H = 480,
    localparam int AW = $clog2(MAX_W * MAX_H)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_valid,
    input logic          s_ready,
    input logic          mem_we,
    input logic          mem_stall,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          error
);
    assert_we_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> s_valid);

    assert_stall_holds_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_stall) |-> !s_ready);

    assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    assert_error_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!mem_we && !done && s_ready));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(mem_addr) < MAX_W * MAX_H));
endmodule

bind img_loader img_loader_chk #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .mem_we    (mem_we),
    .mem_stall (mem_stall),
    .mem_addr  (mem_addr),
    .done      (done),
    .error     (error)
);

// File: tb/img_loader_tb.sv
module img_loader_tb;
    localparam int MW = 16;
    localparam int MH = 12;
    localparam int NP = MW * MH;
    localparam int AW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = '0;
    logic          s_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          mem_stall = 1'b0;
    logic          done;
    logic          error;

    int compared = 0;
    int mismatched = 0;
    int wcount = 0;
    int done_cnt = 0;
    bit double_done = 0;
    bit prev_done = 0;
    bit stall_en = 0;
    bit gap_en = 0;
    logic [AW-1:0] wr_addr [NP];
    logic [7:0]    wr_data [NP];
    logic [7:0]    pix [NP];

    always #10 clk = ~clk;

    img_loader #(.MAX_W(MW), .MAX_H(MH)) u_dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_stall(mem_stall), .done(done), .error(error)
    );

    // Monitor: records accepted writes and done pulses away from the edge.
    always @(negedge clk) begin
        if (mem_we && !mem_stall) begin
            if (wcount < NP) begin
                wr_addr[wcount] = mem_addr;
                wr_data[wcount] = mem_data;
            end
            wcount++;
        end
        if (done) done_cnt++;
        if (done && prev_done) double_done = 1;
        prev_done = done;
    end

    // Random memory stall generator.
    initial begin
        forever begin
            @(posedge clk); #2;
            mem_stall = stall_en && ($urandom % 3 == 0);
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run hung (actual=expired expected=finished)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_addr(input int k, input int w, input int h);
        return (h - 1 - k / w) * w + (k % w);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        s_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit acc;
        if (gap_en && ($urandom % 4 == 0)) begin
            @(posedge clk); #2;
        end
        s_valid = 1'b1;
        s_data  = b;
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            acc = s_ready;
            @(posedge clk); #2;
        end
        s_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] v);
        for (int i = 3; i >= 0; i--) send_byte(v[8*i +: 8]);
    endtask

    // Sends one good image and checks the mapping, count and done (R4, R5, R6).
    task automatic run_image(input int w, input int h);
        int base_w;
        int base_d;
        base_w = wcount;
        base_d = done_cnt;
        for (int k = 0; k < w * h; k++) pix[k] = 8'($urandom);
        send_word(32'hDEAD1337);
        send_word(32'(w));
        send_word(32'(h));
        for (int k = 0; k < w * h; k++) send_byte(pix[k]);
        while (done_cnt == base_d) @(posedge clk);
        repeat (2) @(posedge clk); #2;
        check(wcount - base_w == w * h, "R5 write count", wcount - base_w, w * h);
        check(done_cnt == base_d + 1, "R5 done pulses", done_cnt - base_d, 1);
        check(!double_done, "R5 done width", int'(double_done), 0);
        check(error == 1'b0, "R3 error on good header", int'(error), 0);
        for (int k = 0; k < w * h && k < NP; k++) begin
            check(int'(wr_addr[base_w + k]) == exp_addr(k, w, h), "R4 address",
                  int'(wr_addr[base_w + k]), exp_addr(k, w, h));
            check(wr_data[base_w + k] == pix[k], "R6 data kept",
                  int'(wr_data[base_w + k]), int'(pix[k]));
        end
        wcount = 0;
    endtask

    // Sends a faulty header plus trailing bytes; checks the error handling (R2, R3, R7).
    task automatic run_bad(input logic [31:0] tag, input logic [31:0] w,
                           input logic [31:0] h, input string rq);
        do_reset();
        wcount = 0;
        done_cnt = 0;
        send_word(tag);
        send_word(w);
        send_word(h);
        for (int i = 0; i < 20; i++) send_byte(8'($urandom));
        @(negedge clk);
        check(error == 1'b1, rq, int'(error), 1);
        check(wcount == 0, "R7 no writes after fault", wcount, 0);
        check(done_cnt == 0, "R7 no done after fault", done_cnt, 0);
        check(s_ready == 1'b1, "R7 ready while draining", int'(s_ready), 1);
        @(posedge clk); #2;
    endtask

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        @(negedge clk);
        check(s_ready == 1'b1, "R1 ready after reset", int'(s_ready), 1);
        check(mem_we == 1'b0, "R1 no write after reset", int'(mem_we), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(error == 1'b0, "R1 error after reset", int'(error), 0);
        @(posedge clk); #2;

        run_image(1, 1);
        run_image(MW, MH);
        run_image(1, MH);
        run_image(MW, 1);
        stall_en = 1; gap_en = 1;
        run_image(3, 5);
        for (int t = 0; t < 12; t++) begin
            run_image(1 + int'($urandom % MW), 1 + int'($urandom % MH));
        end
        stall_en = 0; gap_en = 0;

        run_bad(32'hDEAD1336, 32'd4, 32'd4, "R2 magic mismatch");
        run_bad(32'h3713ADDE, 32'd4, 32'd4, "R2 byte order of magic");
        run_bad(32'hDEAD1337, 32'd0, 32'd4, "R3 zero width");
        run_bad(32'hDEAD1337, 32'd4, 32'd0, "R3 zero height");
        run_bad(32'hDEAD1337, 32'(MW + 1), 32'd4, "R3 width over limit");
        run_bad(32'hDEAD1337, 32'd4, 32'(MH + 1), "R3 height over limit");
        run_bad(32'hDEAD1337, 32'h00010000, 32'd2, "R3 big-endian width");

        do_reset();
        @(negedge clk);
        check(error == 1'b0, "R1 error cleared by reset", int'(error), 0);
        @(posedge clk); #2;
        wcount = 0; done_cnt = 0;
        run_image(5, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule